// File: doc/BRIEF.md
# SIMD Accumulator With Pattern Detect

This block is a registered arithmetic and logic stage built around a 58-bit accumulator. Each clock it can add or subtract two 58-bit operands, add an operand into the accumulator or subtract one from it, step the accumulator up or down by one, or load it with one of ten bitwise functions of the two operands. Add and subtract can treat the word as one full-width lane, as two independent 24-bit lanes or as four independent 12-bit lanes. Carries never cross a lane boundary, and each lane reports its own carry-out.

A masked comparator watches the accumulator. It raises one flag when the accumulator equals a supplied pattern on every bit the mask leaves open, and a second flag when it equals the inverse of that pattern on those bits. Surrounding logic uses these flags to detect terminal counts and to make rounding decisions, such as spotting an exact half before convergent rounding. A synchronous clear and a clock enable act on the accumulator and carry registers.

Top module: `simd_accum_alu`

## Requirements
- R1: An active-low `rst_n` clears `acc` and `carry` to zero at once. A high `clr` clears both at the next rising edge whatever `ce` and `op` are.
- R2: With `clr` low and `ce` low, `acc` and `carry` keep their values across the edge.
- R3: The op codes are 0 = a+b, 1 = a-b, 2 = acc+a and 3 = acc-a. In single-lane mode the result is taken modulo 2^58. `carry[0]` is the carry-out, which for a subtract means no borrow, and `carry[3:1]` are 0.
- R4: The lane_mode codes are 0 = one 58-bit lane, 1 = two 24-bit lanes (bits 23:0 and 47:24), 2 = four 12-bit lanes (lane i at bits 12i+11:12i) and 3 = the same as 0. In split modes no carry crosses a lane, `carry[i]` is the carry-out of lane i, unused carry bits are 0, and `acc[57:48]` becomes 0.
- R5: Op 5 adds one to `acc` and op 6 subtracts one from it. Both always work on the full 58-bit word whatever `lane_mode` is, and `carry[0]` follows the R3 rule.
- R6: Op 4 loads `logic_sel`'s function of a and b. The codes are 0 AND, 1 OR, 2 XOR, 3 NAND, 4 NOR, 5 XNOR, 6 a AND NOT b, 7 a OR NOT b, 8 NOT a, 9 a. A valid code clears `carry`. Codes 10 to 15 leave `acc` and `carry` unchanged.
- R7: Op 7 leaves `acc` and `carry` unchanged.
- R8: `pat_hit` is high exactly when `acc` equals `pattern` on every bit where `mask` is 0. It follows the current `acc`, `pattern` and `mask` without a clock.
- R9: `pat_hit_inv` is high exactly when `acc` equals the inverse of `pattern` on every bit where `mask` is 0. Both flags can be high together only when `mask` is all ones.
- R10: A result appears on `acc` and `carry` at the rising edge that samples its inputs (one cycle of latency), and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of accumulator and carries |
| ce | input | 1 | Clock enable for the accumulator register |
| op | input | 3 | Operation code (R3, R5, R6, R7) |
| lane_mode | input | 2 | Lane split for add and subtract (R4) |
| logic_sel | input | 4 | Bitwise function code (R6) |
| a | input | 58 | First operand |
| b | input | 58 | Second operand |
| pattern | input | 58 | Pattern for the detector |
| mask | input | 58 | Detector mask, 1 = bit ignored |
| acc | output | 58 | Accumulator value |
| carry | output | 4 | Per-lane carry-out |
| pat_hit | output | 1 | Masked match against pattern |
| pat_hit_inv | output | 1 | Masked match against inverted pattern |

## Verification
The hardest case to reach is a carry that would leak across a lane boundary while the neighbouring lane produces no carry of its own, together with nonzero operand bits above the split lanes. The stimulus builds operands that are all ones or exactly half scale at every boundary, and sets the bits above the lanes high, so a single leaked carry or stray upper bit changes a visible lane value. Accumulate and count steps are chained, each starting from the previous result. This shows that counting ignores the lane split: a 12-bit lane holding 0xFFF must roll into bit 12 rather than wrap.

// File: rtl/simd_acc_pkg.sv
package simd_acc_pkg;

   typedef enum logic [2:0] {
      OP_ADD     = 3'd0,
      OP_SUB     = 3'd1,
      OP_ACC_ADD = 3'd2,
      OP_ACC_SUB = 3'd3,
      OP_LOGIC   = 3'd4,
      OP_CNT_UP  = 3'd5,
      OP_CNT_DN  = 3'd6,
      OP_HOLD    = 3'd7
   } alu_op_e;

   typedef enum logic [1:0] {
      LM_ONE   = 2'd0,
      LM_TWO   = 2'd1,
      LM_FOUR  = 2'd2,
      LM_ONE_B = 2'd3
   } lane_mode_e;

   localparam logic [3:0] LF_AND   = 4'd0;
   localparam logic [3:0] LF_OR    = 4'd1;
   localparam logic [3:0] LF_XOR   = 4'd2;
   localparam logic [3:0] LF_NAND  = 4'd3;
   localparam logic [3:0] LF_NOR   = 4'd4;
   localparam logic [3:0] LF_XNOR  = 4'd5;
   localparam logic [3:0] LF_ANDN  = 4'd6;
   localparam logic [3:0] LF_ORN   = 4'd7;
   localparam logic [3:0] LF_NOTA  = 4'd8;
   localparam logic [3:0] LF_PASSA = 4'd9;

   localparam int TWO_LANES  = 2;
   localparam int FOUR_LANES = 4;

endpackage

// File: rtl/simd_seg_adder.sv
module simd_seg_adder #(
   parameter int W = 12
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout
);

   if (W < 1) begin : g_bad_w
      $error("simd_seg_adder: W must be positive");
   end

   logic [W:0] wide;

   assign wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
   assign sum  = wide[W-1:0];
   assign cout = wide[W];

endmodule

// File: rtl/simd_lane_bank.sv
module simd_lane_bank #(
   parameter int ACC_W  = 58,
   parameter int LANE_W = 12,
   parameter int LANES  = 4
) (
   input  logic [ACC_W-1:0] x,
   input  logic [ACC_W-1:0] y,
   input  logic             sub,
   output logic [ACC_W-1:0] sum,
   output logic [LANES-1:0] cout
);

   localparam int USED_W = LANE_W * LANES;

   if (USED_W > ACC_W) begin : g_bad_fit
      $error("simd_lane_bank: lanes exceed accumulator width");
   end

   logic [ACC_W-1:0] y_eff;
   assign y_eff = sub ? ~y : y;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      simd_seg_adder #(.W(LANE_W)) u_add (
         .x    (x[i*LANE_W +: LANE_W]),
         .y    (y_eff[i*LANE_W +: LANE_W]),
         .cin  (sub),
         .sum  (sum[i*LANE_W +: LANE_W]),
         .cout (cout[i])
      );
   end

   if (USED_W < ACC_W) begin : g_fill
      assign sum[ACC_W-1:USED_W] = '0;
   end

endmodule

// File: rtl/simd_logic_unit.sv
module simd_logic_unit
   import simd_acc_pkg::*;
#(
   parameter int W = 58
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [3:0]   sel,
   output logic [W-1:0] y,
   output logic         ok
);

   always_comb begin
      ok = 1'b1;
      y  = '0;
      case (sel)
         LF_AND:   y = a & b;
         LF_OR:    y = a | b;
         LF_XOR:   y = a ^ b;
         LF_NAND:  y = ~(a & b);
         LF_NOR:   y = ~(a | b);
         LF_XNOR:  y = ~(a ^ b);
         LF_ANDN:  y = a & ~b;
         LF_ORN:   y = a | ~b;
         LF_NOTA:  y = ~a;
         LF_PASSA: y = a;
         default:  ok = 1'b0;
      endcase
   end

endmodule

// File: rtl/simd_pattern_det.sv
module simd_pattern_det #(
   parameter int W = 58
) (
   input  logic [W-1:0] value,
   input  logic [W-1:0] pattern,
   input  logic [W-1:0] mask,
   output logic         hit,
   output logic         hit_inv
);

   logic [W-1:0] diff_t;
   logic [W-1:0] diff_c;

   assign diff_t  = (value ^ pattern) & ~mask;
   assign diff_c  = (value ^ ~pattern) & ~mask;
   assign hit     = ~|diff_t;
   assign hit_inv = ~|diff_c;

   // R9: a bit cannot equal both the pattern and its inverse unless masked
   always_comb begin
      p_flag_excl_r9: assert (!(hit && hit_inv) || (&mask));
   end

endmodule

// File: rtl/simd_accum_alu.sv
module simd_accum_alu
   import simd_acc_pkg::*;
#(
   parameter int ACC_W  = 58,
   parameter int DUAL_W = 24,
   parameter int QUAD_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              ce,
   input  logic [2:0]        op,
   input  logic [1:0]        lane_mode,
   input  logic [3:0]        logic_sel,
   input  logic [ACC_W-1:0]  a,
   input  logic [ACC_W-1:0]  b,
   input  logic [ACC_W-1:0]  pattern,
   input  logic [ACC_W-1:0]  mask,
   output logic [ACC_W-1:0]  acc,
   output logic [3:0]        carry,
   output logic              pat_hit,
   output logic              pat_hit_inv
);

   localparam int CAR_W  = FOUR_LANES;
   localparam int DUAL_U = TWO_LANES * DUAL_W;
   localparam int QUAD_U = FOUR_LANES * QUAD_W;
   localparam logic [ACC_W-1:0] ONE = {{(ACC_W-1){1'b0}}, 1'b1};

   if (DUAL_U > ACC_W) begin : g_bad_dual
      $error("simd_accum_alu: two lanes of DUAL_W exceed ACC_W");
   end
   if (QUAD_U > ACC_W) begin : g_bad_quad
      $error("simd_accum_alu: four lanes of QUAD_W exceed ACC_W");
   end
   if (QUAD_W < 1 || DUAL_W < 1) begin : g_bad_lane
      $error("simd_accum_alu: lane widths must be positive");
   end

   alu_op_e    op_c;
   lane_mode_e lm_c;
   assign op_c = alu_op_e'(op);
   assign lm_c = lane_mode_e'(lane_mode);

   logic [ACC_W-1:0] acc_q;
   logic [CAR_W-1:0] car_q;

   // operand routing
   logic             use_acc, is_sub, is_cnt, is_arith;
   logic [ACC_W-1:0] x_op, y_op;

   always_comb begin
      use_acc  = 1'b0;
      is_sub   = 1'b0;
      is_cnt   = 1'b0;
      is_arith = 1'b1;
      y_op     = b;
      case (op_c)
         OP_ADD:     ;
         OP_SUB:     is_sub = 1'b1;
         OP_ACC_ADD: begin use_acc = 1'b1; y_op = a; end
         OP_ACC_SUB: begin use_acc = 1'b1; y_op = a; is_sub = 1'b1; end
         OP_CNT_UP:  begin use_acc = 1'b1; y_op = ONE; is_cnt = 1'b1; end
         OP_CNT_DN:  begin use_acc = 1'b1; y_op = ONE; is_cnt = 1'b1; is_sub = 1'b1; end
         default:    is_arith = 1'b0;
      endcase
      x_op = use_acc ? acc_q : a;
   end

   // three lane arrangements computed side by side
   logic [ACC_W-1:0]      sum_one, sum_two, sum_four;
   logic [0:0]            c_one;
   logic [TWO_LANES-1:0]  c_two;
   logic [FOUR_LANES-1:0] c_four;

   simd_lane_bank #(.ACC_W(ACC_W), .LANE_W(ACC_W), .LANES(1)) u_bank_one (
      .x (x_op), .y (y_op), .sub (is_sub), .sum (sum_one), .cout (c_one)
   );
   simd_lane_bank #(.ACC_W(ACC_W), .LANE_W(DUAL_W), .LANES(TWO_LANES)) u_bank_two (
      .x (x_op), .y (y_op), .sub (is_sub), .sum (sum_two), .cout (c_two)
   );
   simd_lane_bank #(.ACC_W(ACC_W), .LANE_W(QUAD_W), .LANES(FOUR_LANES)) u_bank_four (
      .x (x_op), .y (y_op), .sub (is_sub), .sum (sum_four), .cout (c_four)
   );

   logic [ACC_W-1:0] ar_res;
   logic [CAR_W-1:0] ar_car;

   always_comb begin
      ar_res = sum_one;
      ar_car = {{(CAR_W-1){1'b0}}, c_one};
      if (!is_cnt) begin
         case (lm_c)
            LM_TWO: begin
               ar_res = sum_two;
               ar_car = {{(CAR_W-TWO_LANES){1'b0}}, c_two};
            end
            LM_FOUR: begin
               ar_res = sum_four;
               ar_car = c_four;
            end
            default: ;
         endcase
      end
   end

   // bitwise functions
   logic [ACC_W-1:0] lu_y;
   logic             lu_ok;

   simd_logic_unit #(.W(ACC_W)) u_logic (
      .a (a), .b (b), .sel (logic_sel), .y (lu_y), .ok (lu_ok)
   );

   // next-state selection
   logic             wr_en;
   logic [ACC_W-1:0] acc_d;
   logic [CAR_W-1:0] car_d;

   always_comb begin
      wr_en = 1'b0;
      acc_d = ar_res;
      car_d = ar_car;
      if (is_arith) begin
         wr_en = 1'b1;
      end else if (op_c == OP_LOGIC && lu_ok) begin
         wr_en = 1'b1;
         acc_d = lu_y;
         car_d = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         car_q <= '0;
      end else if (clr) begin
         acc_q <= '0;
         car_q <= '0;
      end else if (ce && wr_en) begin
         acc_q <= acc_d;
         car_q <= car_d;
      end
   end

   assign acc   = acc_q;
   assign carry = car_q;

   simd_pattern_det #(.W(ACC_W)) u_pdet (
      .value (acc_q), .pattern (pattern), .mask (mask),
      .hit (pat_hit), .hit_inv (pat_hit_inv)
   );

   // ---------------- assertions ----------------
   p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (acc == '0) && (carry == '0));

   p_hold_ce_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !ce) |=> $stable(acc) && $stable(carry));

   p_full_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && !clr && op <= 3'd3 && (lane_mode == 2'd0 || lane_mode == 2'd3))
      |=> (carry[3:1] == 3'b000));

   p_dual_iso_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && !clr && op <= 3'd3 && lane_mode == 2'd1)
      |=> (carry[3:2] == 2'b00) && ((acc >> DUAL_U) == '0));

   p_quad_iso_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && !clr && op <= 3'd3 && lane_mode == 2'd2)
      |=> ((acc >> QUAD_U) == '0));

   p_count_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && !clr && op == 3'd5) |=> (acc == $past(acc) + ONE));

   p_count_dn_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && !clr && op == 3'd6) |=> (acc == $past(acc) - ONE));

   p_bad_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && op == 3'd4 && logic_sel > 4'd9)
      |=> $stable(acc) && $stable(carry));

   p_logic_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && !clr && op == 3'd4 && logic_sel <= 4'd9) |=> (carry == '0));

   p_hold_op_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && op == 3'd7) |=> $stable(acc) && $stable(carry));

endmodule

// File: tb/sim_simd_accum_alu.sv
module sim_simd_accum_alu;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr = 1'b0;
   logic        ce = 1'b0;
   logic [2:0]  op = 3'd7;
   logic [1:0]  lane_mode = 2'd0;
   logic [3:0]  logic_sel = 4'd0;
   logic [57:0] a = '0;
   logic [57:0] b = '0;
   logic [57:0] pattern = '0;
   logic [57:0] mask = '0;
   logic [57:0] acc;
   logic [3:0]  carry;
   logic        pat_hit, pat_hit_inv;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   simd_accum_alu u0 (
      .clk (clk), .rst_n (rst_n), .clr (clr), .ce (ce), .op (op),
      .lane_mode (lane_mode), .logic_sel (logic_sel), .a (a), .b (b),
      .pattern (pattern), .mask (mask), .acc (acc), .carry (carry),
      .pat_hit (pat_hit), .pat_hit_inv (pat_hit_inv)
   );

   localparam logic [57:0] ONES = 58'h3FF_FFFF_FFFF_FFFF;
   localparam logic [57:0] LA   = 58'h2C3_C3C3_C3C3_C3C3;
   localparam logic [57:0] LB   = 58'h0FF_00FF_00FF_00FF;

   typedef struct packed {
      logic [2:0]  op;
      logic [1:0]  md;
      logic [3:0]  ls;
      logic [57:0] a;
      logic [57:0] b;
      logic [57:0] e;
      logic [3:0]  c;
   } vec_t;

   localparam int VN = 29;
   localparam vec_t VT [VN] = '{
      '{3'd0, 2'd0, 4'd0, 58'd5, 58'd3, 58'd8, 4'b0000},
      '{3'd0, 2'd0, 4'd0, ONES, 58'd1, 58'd0, 4'b0001},
      '{3'd1, 2'd0, 4'd0, 58'd10, 58'd3, 58'd7, 4'b0001},
      '{3'd1, 2'd0, 4'd0, 58'd3, 58'd10, 58'h3FF_FFFF_FFFF_FFF9, 4'b0000},
      '{3'd0, 2'd1, 4'd0, {10'h3FF, 48'h000001FFFFFF}, {10'h000, 48'h000001000001},
        {10'h0, 48'h000002000000}, 4'b0001},
      '{3'd0, 2'd2, 4'd0, {10'h155, 48'hFFF0018007FF}, {10'h2AA, 48'h001FFF800001},
        {10'h0, 48'h000000000800}, 4'b1110},
      '{3'd1, 2'd2, 4'd0, {10'h0, 48'h005000010100}, {10'h0, 48'h00600000F001},
        {10'h0, 48'hFFF0000010FF}, 4'b0111},
      '{3'd1, 2'd1, 4'd0, {10'h0, 48'h000010000000}, {10'h0, 48'h000001000001},
        {10'h0, 48'h00000FFFFFFF}, 4'b0010},
      '{3'd2, 2'd0, 4'd0, 58'd1, 58'd0, {10'h0, 48'h000010000000}, 4'b0000},
      '{3'd2, 2'd1, 4'd0, {10'h0, 48'h000001000001}, 58'd0, {10'h0, 48'h000011000001}, 4'b0000},
      '{3'd3, 2'd2, 4'd0, 58'd2, 58'd0, {10'h0, 48'h000011000FFF}, 4'b1110},
      '{3'd5, 2'd2, 4'd0, 58'd0, 58'd0, {10'h0, 48'h000011001000}, 4'b0000},
      '{3'd6, 2'd1, 4'd0, 58'd0, 58'd0, {10'h0, 48'h000011000FFF}, 4'b0001},
      '{3'd3, 2'd0, 4'd0, {10'h0, 48'h000011001000}, 58'd0, ONES, 4'b0000},
      '{3'd5, 2'd2, 4'd0, 58'd0, 58'd0, 58'd0, 4'b0001},
      '{3'd6, 2'd0, 4'd0, 58'd0, 58'd0, ONES, 4'b0000},
      '{3'd4, 2'd0, 4'd0, LA, LB, LA & LB, 4'b0000},
      '{3'd4, 2'd0, 4'd1, LA, LB, LA | LB, 4'b0000},
      '{3'd4, 2'd0, 4'd2, LA, LB, LA ^ LB, 4'b0000},
      '{3'd4, 2'd0, 4'd3, LA, LB, ~(LA & LB), 4'b0000},
      '{3'd4, 2'd0, 4'd4, LA, LB, ~(LA | LB), 4'b0000},
      '{3'd4, 2'd0, 4'd5, LA, LB, ~(LA ^ LB), 4'b0000},
      '{3'd4, 2'd0, 4'd6, LA, LB, LA & ~LB, 4'b0000},
      '{3'd4, 2'd0, 4'd7, LA, LB, LA | ~LB, 4'b0000},
      '{3'd4, 2'd0, 4'd8, LA, LB, ~LA, 4'b0000},
      '{3'd4, 2'd0, 4'd9, LA, LB, LA, 4'b0000},
      '{3'd4, 2'd0, 4'd12, LB, LA, LA, 4'b0000},
      '{3'd7, 2'd0, 4'd0, LB, LB, LA, 4'b0000},
      '{3'd0, 2'd3, 4'd0, ONES, 58'd1, 58'd0, 4'b0001}
   };

   function automatic string vtag(input logic [2:0] o, input logic [1:0] m);
      if (o == 3'd5 || o == 3'd6) return "R5";
      if (o == 3'd4) return "R6";
      if (o == 3'd7) return "R7";
      if (m == 2'd1 || m == 2'd2) return "R4";
      return "R3";
   endfunction

   task automatic chk58(input string req, input logic [57:0] act, input logic [57:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s acc actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk4(input string req, input logic [3:0] act, input logic [3:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s carry actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic chkf(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s flag actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic step(input logic [2:0] o, input logic [1:0] m, input logic [3:0] s,
                       input logic [57:0] va, input logic [57:0] vb,
                       input logic vce, input logic vclr);
      @(negedge clk);
      op = o; lane_mode = m; logic_sel = s; a = va; b = vb; ce = vce; clr = vclr;
      @(posedge clk);
      #2;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk58("R1 reset", acc, 58'd0);
      chk4("R1 reset", carry, 4'd0);
      chkf("R8 zero vs zero pattern", pat_hit, 1'b1);
      @(negedge clk);
      rst_n = 1'b1;

      // table walk
      for (int i = 0; i < VN; i++) begin
         step(VT[i].op, VT[i].md, VT[i].ls, VT[i].a, VT[i].b, 1'b1, 1'b0);
         chk58(vtag(VT[i].op, VT[i].md), acc, VT[i].e);
         chk4(vtag(VT[i].op, VT[i].md), carry, VT[i].c);
      end

      // R10: value changes only at the sampling edge
      @(negedge clk);
      op = 3'd0; lane_mode = 2'd0; a = 58'd1; b = 58'd1; ce = 1'b1; clr = 1'b0;
      #1;
      chk58("R10 before edge", acc, 58'd0);
      @(posedge clk);
      #2;
      chk58("R10 after edge", acc, 58'd2);
      chk4("R10 after edge", carry, 4'b0000);

      // R3 wrap with carry, then R2 hold
      step(3'd0, 2'd0, 4'd0, ONES, 58'd3, 1'b1, 1'b0);
      chk58("R3 wrap", acc, 58'd2);
      chk4("R3 wrap", carry, 4'b0001);
      step(3'd1, 2'd0, 4'd0, 58'd0, 58'd5, 1'b0, 1'b0);
      chk58("R2 ce low", acc, 58'd2);
      chk4("R2 ce low", carry, 4'b0001);

      // R1 clear with ce low, and clear over a pending op
      step(3'd0, 2'd0, 4'd0, 58'd9, 58'd9, 1'b0, 1'b1);
      chk58("R1 clr ce low", acc, 58'd0);
      chk4("R1 clr ce low", carry, 4'b0000);
      step(3'd0, 2'd0, 4'd0, 58'd5, 58'd0, 1'b1, 1'b0);
      chk58("R3 load", acc, 58'd5);
      step(3'd0, 2'd0, 4'd0, 58'd9, 58'd9, 1'b1, 1'b1);
      chk58("R1 clr priority", acc, 58'd0);

      // pattern detector
      step(3'd0, 2'd0, 4'd0, LA, 58'd0, 1'b1, 1'b0);
      step(3'd7, 2'd0, 4'd0, 58'd0, 58'd0, 1'b0, 1'b0);
      pattern = LA; mask = '0; #1;
      chkf("R8 exact", pat_hit, 1'b1);
      chkf("R9 exact", pat_hit_inv, 1'b0);
      pattern = ~LA; #1;
      chkf("R8 inverse", pat_hit, 1'b0);
      chkf("R9 inverse", pat_hit_inv, 1'b1);
      pattern = LA ^ 58'h20; mask = 58'h20; #1;
      chkf("R8 masked bit", pat_hit, 1'b1);
      mask = '0; #1;
      chkf("R8 unmasked diff", pat_hit, 1'b0);
      chkf("R9 unmasked diff", pat_hit_inv, 1'b0);
      mask = ONES; #1;
      chkf("R8 all masked", pat_hit, 1'b1);
      chkf("R9 all masked", pat_hit_inv, 1'b1);
      mask = '0;

      // R1 asynchronous reset
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk58("R1 async", acc, 58'd0);
      @(negedge clk);
      rst_n = 1'b1;

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule